// File: doc/BRIEF.md
# Slotted Transmit Frame Reader

This block sends frames that software has already written into a shared packet buffer. The buffer holds the receive slots first and the transmit slots after them, and every slot is the same size. Software picks a transmit slot and a byte count through a small 32-bit register port, turns on the event enable, and then writes the start register. The block reads that many bytes from the chosen slot over a byte-wide RAM read port and sends them out as a byte stream, with a marker on the final byte.

When a frame is finished, the block sets a pending flag, which drives the shared interrupt line. Software clears the flag by writing to the pending register. While a frame is in flight, a ready register reads 0. The slot and length values are taken when the frame starts, so software may prepare the next frame while the current one is still going out. The RAM is outside the block and returns read data one cycle after the address. The MAC, the PHY and the CRC are also outside it.

Top module: `tx_frame_reader`

## Requirements
- R1: Registers are decoded from a byte address as follows: start 0x18, ready 0x1C, level 0x20, slot 0x24, length 0x28, status 0x2C, pending 0x30, enable 0x34. Any other address reads 0 and ignores writes. After reset, ready reads 1, every other register reads 0, `irq_pending` is 0 and `tx_valid` is 0.
- R2: A write to slot stores the written value modulo TX_SLOTS.
- R3: A write to length stores the written value, except that a value above SLOT_BYTES is stored as SLOT_BYTES.
- R4: A started frame sends exactly length bytes, one per cycle, in increasing offset order. Byte k comes from RAM address RX_SLOTS*SLOT_BYTES + slot*SLOT_BYTES + k. `tx_valid` rises one cycle after the address is issued, with `tx_data` equal to `mem_rdata`. `tx_last` is high only on the final byte.
- R5: A write to start launches a frame only if the enable register is nonzero. Otherwise it has no effect: no bytes are sent and pending is not set.
- R6: Ready reads 0 from the cycle after a launch until the frame finishes, and reads 1 afterwards.
- R7: When a frame finishes and the enable register is nonzero, pending becomes 1. A write of any value to pending clears it. `irq_pending` always equals pending.
- R8: Writes to the ready register are ignored.
- R9: A write to start while a frame is in progress is ignored. Slot and length writes made during a frame do not change that frame.
- R10: A frame with length 0 sends no bytes, finishes one cycle after launch, and still sets pending.
- R11: The level, status and enable registers read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_rd | output | 1 | Packet RAM read request |
| mem_addr | output | MEM_AW | Packet RAM byte address |
| mem_rdata | input | 8 | Packet RAM data, valid one cycle after the request |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| irq_pending | output | 1 | Frame-done pending flag |

## Verification
The main function is exercised with frames of several kinds:
- A short 4-byte frame from slot 0. This shows the base offset past the receive area.
- A 17-byte frame from slot 1, with extra start, slot and length writes issued while it runs. This separates latched values from live register values and shows that a start during a frame is dropped.
- A zero-length frame. This covers completion without any data.
- A frame whose length write was clamped to the full slot. This shows that the clamp reaches the byte count actually sent.

A start with the enable cleared shows the gating. Slot writes of 5 and 2 show the modulo reduction.

// File: rtl/tx_frame_reader.sv
module tx_frame_reader #(
  parameter int TX_SLOTS   = 2,
  parameter int RX_SLOTS   = 2,
  parameter int SLOT_BYTES = 2048,
  parameter int MEM_AW     = $clog2((TX_SLOTS + RX_SLOTS) * SLOT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq_pending
);
  localparam int LEN_W  = $clog2(SLOT_BYTES + 1);
  localparam int SLOT_W = (TX_SLOTS > 1) ? $clog2(TX_SLOTS) : 1;
  localparam logic [7:0] A_START = 8'h18, A_READY = 8'h1C, A_LEVEL = 8'h20,
                         A_SLOT  = 8'h24, A_LEN   = 8'h28, A_STAT  = 8'h2C,
                         A_PEND  = 8'h30, A_EN    = 8'h34;

  logic [31:0]       en_q, lvl_q, sts_q;
  logic [SLOT_W-1:0] slot_q, cur_slot;
  logic [LEN_W-1:0]  len_q, cur_len, off_q;
  logic              pend_q, busy_q, rd_v_q, rd_last_q;

  logic wr_start, launch, issue, finish;
  assign wr_start = reg_we && (reg_addr == A_START);
  assign launch   = wr_start && (en_q != 32'd0) && !busy_q;
  assign issue    = busy_q && (off_q != cur_len);
  assign finish   = busy_q && ((cur_len == '0) || rd_last_q);

  assign mem_rd   = issue;
  assign mem_addr = MEM_AW'(RX_SLOTS * SLOT_BYTES)
                  + MEM_AW'(cur_slot) * MEM_AW'(SLOT_BYTES)
                  + MEM_AW'(off_q);

  assign tx_valid    = rd_v_q;
  assign tx_last     = rd_last_q;
  assign tx_data     = mem_rdata;
  assign irq_pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      lvl_q  <= '0;
      sts_q  <= '0;
      slot_q <= '0;
      len_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_EN:    en_q   <= reg_wdata;
        A_LEVEL: lvl_q  <= reg_wdata;
        A_STAT:  sts_q  <= reg_wdata;
        A_SLOT:  slot_q <= SLOT_W'(reg_wdata % 32'(TX_SLOTS));
        A_LEN:   len_q  <= (reg_wdata > 32'(SLOT_BYTES)) ? LEN_W'(SLOT_BYTES)
                                                          : reg_wdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cur_slot  <= '0;
      cur_len   <= '0;
      off_q     <= '0;
      rd_v_q    <= 1'b0;
      rd_last_q <= 1'b0;
    end else begin
      rd_v_q    <= issue;
      rd_last_q <= issue && (off_q == cur_len - LEN_W'(1));
      if (launch) begin
        busy_q   <= 1'b1;
        cur_slot <= slot_q;
        cur_len  <= len_q;
        off_q    <= '0;
      end else begin
        if (issue)  off_q  <= off_q + LEN_W'(1);
        if (finish) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   pend_q <= 1'b0;
    else if (finish && (en_q != 32'd0))           pend_q <= 1'b1;
    else if (reg_we && (reg_addr == A_PEND))      pend_q <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      A_READY: reg_rdata = {31'd0, !busy_q};
      A_LEVEL: reg_rdata = lvl_q;
      A_SLOT:  reg_rdata = 32'(slot_q);
      A_LEN:   reg_rdata = 32'(len_q);
      A_STAT:  reg_rdata = sts_q;
      A_PEND:  reg_rdata = {31'd0, pend_q};
      A_EN:    reg_rdata = en_q;
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module tx_frame_reader_chk #(
  parameter int TX_SLOTS   = 2,
  parameter int RX_SLOTS   = 2,
  parameter int SLOT_BYTES = 2048,
  parameter int MEM_AW     = 13,
  parameter int LEN_W      = 12,
  parameter int SLOT_W     = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic              mem_rd,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              tx_valid,
  input logic              tx_last,
  input logic              irq_pending,
  input logic [31:0]       en_q,
  input logic              busy_q,
  input logic [SLOT_W-1:0] slot_q,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [LEN_W-1:0]  len_q
);
  AST_ADDR_IN_TX_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (32'(mem_addr) >= 32'(RX_SLOTS * SLOT_BYTES)) &&
               (32'(mem_addr) <  32'((RX_SLOTS + TX_SLOTS) * SLOT_BYTES))); // R4
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid); // R4
  AST_NO_LAUNCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h18 && en_q == 32'd0 && !busy_q) |=> !busy_q); // R5
  AST_BUSY_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy_q); // R6
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h30 && !busy_q) |=> !irq_pending); // R7
  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    32'(len_q) <= 32'(SLOT_BYTES)); // R3
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot_q) < 32'(TX_SLOTS)); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h18 && busy_q) |=> (cur_slot == $past(cur_slot))); // R9
endmodule

bind tx_frame_reader tx_frame_reader_chk #(
  .TX_SLOTS(TX_SLOTS), .RX_SLOTS(RX_SLOTS), .SLOT_BYTES(SLOT_BYTES),
  .MEM_AW(MEM_AW), .LEN_W(LEN_W), .SLOT_W(SLOT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_last(tx_last),
  .irq_pending(irq_pending), .en_q(en_q), .busy_q(busy_q), .slot_q(slot_q),
  .cur_slot(cur_slot), .len_q(len_q)
);

// File: tb/tx_frame_reader_tb_top.sv
module tx_frame_reader_tb_top;
  localparam int TXS = 2, RXS = 2, SB = 2048, AW = 13;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h1C;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_rd, tx_valid, tx_last, irq_pending;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = '0, tx_data;
  int vectors = 0, fails = 0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  tx_frame_reader #(.TX_SLOTS(TXS), .RX_SLOTS(RXS), .SLOT_BYTES(SB)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .irq_pending(irq_pending));

  function automatic logic [7:0] mv(int a);
    return 8'((a * 13 + (a >> 7)) ^ 8'h5A);
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mv(int'(mem_addr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (exp_q.size() == 0) chk("R4/R5/R9 unexpected byte", {23'd0, tx_last, tx_data}, 32'h1FF);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R4 byte", {23'd0, tx_last, tx_data}, {23'd0, e});
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h1C;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic expect_frame(int slot, int len);
    for (int i = 0; i < len; i++)
      exp_q.push_back({(i == len - 1), mv(RXS * SB + slot * SB + i)});
  endtask

  task automatic wait_idle();
    reg_addr = 8'h1C;
    do begin @(negedge clk); #1; end while (reg_rdata != 32'd1);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all R) actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and map
    rd(8'h1C, v); chk("R1 ready", v, 1);
    for (int a = 8'h18; a <= 8'h34; a += 4) begin
      if (a != 8'h1C) begin rd(8'(a), v); chk("R1 reg zero", v, 0); end
    end
    chk("R1 irq", {31'd0, irq_pending}, 0);
    chk("R1 valid", {31'd0, tx_valid}, 0);

    // R5 start with enable cleared
    wr(8'h28, 8);
    wr(8'h18, 1);
    rd(8'h1C, v); chk("R5 ready stays", v, 1);
    repeat (12) @(negedge clk);
    rd(8'h30, v); chk("R5 no pending", v, 0);

    // R11 readback, unmapped
    wr(8'h34, 32'hA5A5_0001); rd(8'h34, v); chk("R11 enable", v, 32'hA5A5_0001);
    wr(8'h20, 32'h1234_5678); rd(8'h20, v); chk("R11 level", v, 32'h1234_5678);
    wr(8'h2C, 32'hCAFE_0003); rd(8'h2C, v); chk("R11 status", v, 32'hCAFE_0003);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk("R1 unmapped", v, 0);

    // R2 slot modulo
    wr(8'h24, 5); rd(8'h24, v); chk("R2 slot 5", v, 1);
    wr(8'h24, 2); rd(8'h24, v); chk("R2 slot 2", v, 0);
    // R3 length clamp
    wr(8'h28, 3000); rd(8'h28, v); chk("R3 clamp", v, SB);
    wr(8'h28, SB);   rd(8'h28, v); chk("R3 exact", v, SB);
    // R8 ready write ignored
    wr(8'h1C, 0); rd(8'h1C, v); chk("R8 ready", v, 1);

    // R4 R6 R7 short frame, slot 0
    wr(8'h24, 0); wr(8'h28, 4);
    expect_frame(0, 4);
    wr(8'h18, 1);
    rd(8'h1C, v); chk("R6 busy", v, 0);
    wait_idle();
    chk("R4 all bytes", exp_q.size(), 0);
    rd(8'h30, v); chk("R7 pending set", v, 1);
    chk("R7 irq", {31'd0, irq_pending}, 1);
    wr(8'h30, 32'h0); rd(8'h30, v); chk("R7 cleared", v, 0);
    chk("R7 irq cleared", {31'd0, irq_pending}, 0);

    // R9 frame slot 1 len 17 with writes during it
    wr(8'h24, 1); wr(8'h28, 17);
    expect_frame(1, 17);
    wr(8'h18, 1);
    wr(8'h18, 1);
    wr(8'h24, 0);
    wr(8'h28, 3);
    wait_idle();
    chk("R9 all bytes", exp_q.size(), 0);
    rd(8'h30, v); chk("R9 pending", v, 1);
    wr(8'h30, 32'h7);

    // R10 zero length
    wr(8'h28, 0);
    wr(8'h18, 1);
    wait_idle();
    repeat (4) @(negedge clk);
    rd(8'h30, v); chk("R10 pending", v, 1);
    wr(8'h30, 1);

    // R3 clamped length drives full-slot frame
    wr(8'h24, 1); wr(8'h28, 5000);
    expect_frame(1, SB);
    wr(8'h18, 1);
    wait_idle();
    chk("R3 full frame sent", exp_q.size(), 0);
    rd(8'h1C, v); chk("R6 ready after", v, 1);

    summary();
  end
endmodule